// File: doc/BRIEF.md
# Indirect-Addressed Serial Channel Register Front End

This block is the host-facing register front end of one asynchronous serial channel. The host sees only two addresses: a control address and a data address. On the control address, every access to a configuration register takes two steps. The first write loads a register index. The next control access, read or write, reaches the indexed register, and the index then falls back to zero. A control read with no index loaded returns the channel status byte. Register 0 is also a command port: certain byte values written to it produce one-cycle command pulses for the latch and interrupt logic around the block.

The block keeps the configuration the rest of the channel needs:

- receiver and transmitter enables;
- character lengths;
- modem-control outputs;
- clock multiplier, stop-bit and parity selections;
- the 16-bit baud time constant;
- the baud-generator enable and clock-routing flags.

It also holds one transmit byte and one receive byte. The serial shifter drains the transmit byte through `tx_load` and delivers received bytes through `rx_strobe`. On a read, the receive byte is masked to the configured character length. A parameter selects whether the block is channel A or channel B, which sets the byte that resets the channel through register 9.

Top module: `ser_chan_ctl`

## Requirements
- R1: A control-address write while no index is loaded stores `bus_wdata[3:0]` as the register index. The next control access, read or write, targets that register, and the index then returns to zero with none loaded. While an index is loaded, a control read of any register other than 0, 12 or 13 returns 0x00.
- R2: A control read with no index loaded (register 0) returns a status byte: bit 0 is receive-byte-available, bit 2 is transmit-holding-empty, bit 7 follows `brk_in`, and all other bits are 0.
- R3: Register 3 sets the receiver: bit 0 drives `rx_en` and bits 7:6 drive `rx_len`. Register 5 sets the transmitter: bit 3 drives `tx_en`, bits 6:5 drive `tx_len`, bit 7 drives `dtr` and bit 1 drives `rts`.
- R4: Register 4 bits 7:6 drive `clk_mode`, bits 3:2 drive `stop_sel` and bits 1:0 drive `parity_sel`.
- R5: `time_const` is register 13 in the high byte and register 12 in the low byte. Control reads of registers 12 and 13 return the stored bytes.
- R6: `brg_run` is high only while register 14 holds 0x07. `brg_clocks` is high only while register 11 holds 0x56.
- R7: A register 0 write of 0x10, 0x28, 0x38 or 0xF0 raises `cmd_ext_rst`, `cmd_txint_clr`, `cmd_ius_rst` or `cmd_err_rst` respectively, for exactly the one cycle after the write. Any other value raises none of them.
- R8: A register 9 write of this channel's reset code (0x80 for channel A, the default; 0x40 for channel B) clears every configuration register and both holding bytes to 0. It also sets transmit-holding-empty and clears receive-byte-available. The other channel's code has no effect.
- R9: A data-address write loads the transmit holding byte (`tx_byte`) and raises `tx_pending`. `tx_load` clears `tx_pending` only while `tx_en` is high and a byte is pending, and it is ignored otherwise. A data write in the same cycle as `tx_load` wins.
- R10: `rx_strobe` stores `rx_byte` and sets receive-byte-available only while `rx_en` is high. A data-address read returns the stored byte masked by `rx_len` and clears the flag. The masks are 00→0x1F, 10→0x3F, 01→0x7F and 11→0xFF. An accepted strobe in the same cycle as a data read leaves the flag set.
- R11: While `rst_n` is low at a clock edge, every register, flag and command output goes to its cleared state: index zero with none loaded, configuration 0, transmit-holding-empty set, receive flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control address, 1 = data address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (0 when not reading) |
| brk_in | input | 1 | Break/abort condition from the line |
| rx_strobe | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Byte delivered by the receiver |
| tx_load | input | 1 | Shifter takes the transmit holding byte |
| tx_byte | output | 8 | Transmit holding byte |
| tx_pending | output | 1 | Transmit holding byte not yet taken |
| rx_en | output | 1 | Receiver enable |
| rx_len | output | 2 | Receive character length code |
| tx_en | output | 1 | Transmitter enable |
| tx_len | output | 2 | Transmit character length code |
| dtr | output | 1 | Data-terminal-ready output |
| rts | output | 1 | Request-to-send output |
| clk_mode | output | 2 | Clock multiplier selection |
| stop_sel | output | 2 | Stop-bit selection |
| parity_sel | output | 2 | Parity selection |
| time_const | output | 16 | Baud time constant |
| brg_run | output | 1 | Baud generator enabled from the peripheral clock |
| brg_clocks | output | 1 | Receive and transmit clocks taken from the baud generator |
| cmd_ext_rst | output | 1 | Pulse: reset external/status latches |
| cmd_txint_clr | output | 1 | Pulse: clear pending transmit interrupt |
| cmd_ius_rst | output | 1 | Pulse: reset highest interrupt under service |
| cmd_err_rst | output | 1 | Pulse: reset transmit underrun and error latches |

## Verification
The two-step access is driven with idle reads, with indexed reads and writes, and with an indexed read followed directly by an idle read. This shows whether the index really falls back to zero after one access rather than staying loaded. Each command byte is written in turn, along with one near-miss value, so that a wrong decode or a stretched pulse shows up on the exact cycle.

The receive mask is tried with an all-ones byte at every length code, which separates each mask from its neighbours. Collisions are tested in both directions: a strobe against a data read, and a data write against `tx_load`. A transmit load while disabled and a receive strobe while disabled show whether the enables gate the holding bytes. The channel reset is tried first with the other channel's code and then with its own, after every register has been given a non-zero value.

// File: rtl/ser_chan_pkg.sv
// Shared widths, register indices, command codes and the receive mask
// function for the serial channel register front end.
package ser_chan_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;
    localparam int LEN_W  = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    // Register indices whose numbers the host software depends on.
    localparam logic [IDX_W-1:0] IX_CMD    = 4'd0;
    localparam logic [IDX_W-1:0] IX_RXCFG  = 4'd3;
    localparam logic [IDX_W-1:0] IX_FRAME  = 4'd4;
    localparam logic [IDX_W-1:0] IX_TXCFG  = 4'd5;
    localparam logic [IDX_W-1:0] IX_RESET  = 4'd9;
    localparam logic [IDX_W-1:0] IX_CLKSRC = 4'd11;
    localparam logic [IDX_W-1:0] IX_TCLO   = 4'd12;
    localparam logic [IDX_W-1:0] IX_TCHI   = 4'd13;
    localparam logic [IDX_W-1:0] IX_BRGCTL = 4'd14;

    // Command bytes decoded on register 0.
    localparam byte_t CMD_EXT   = 8'h10;
    localparam byte_t CMD_TXCLR = 8'h28;
    localparam byte_t CMD_IUS   = 8'h38;
    localparam byte_t CMD_ERR   = 8'hF0;

    // Channel reset codes written to register 9.
    localparam byte_t RST_CODE_A = 8'h80;
    localparam byte_t RST_CODE_B = 8'h40;

    // Configuration values that turn on the baud generator paths.
    localparam byte_t BRG_ON     = 8'h07;
    localparam byte_t CLKSRC_BRG = 8'h56;

    // One-cycle command pulses.
    typedef struct packed {
        logic ext_rst;
        logic txint_clr;
        logic ius_rst;
        logic err_rst;
    } cmd_t;

    // Receive mask for a character length code (00=5, 01=7, 10=6, 11=8 bits).
    function automatic byte_t len_mask(input logic [LEN_W-1:0] code);
        case (code)
            2'b00:   len_mask = 8'h1F;
            2'b01:   len_mask = 8'h7F;
            2'b10:   len_mask = 8'h3F;
            default: len_mask = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/ser_ptr_seq.sv
// Register index sequencer for the control address.
// An idle control write loads the index and arms the sequencer. The next
// control access uses the index, then the index returns to zero.
// Assumes at most one host access per cycle.
module ser_ptr_seq
    import ser_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic [IDX_W-1:0] wr_idx,
    output logic             armed,
    output logic [IDX_W-1:0] cur_idx,
    output logic             reg_wr
);

    logic             armed_q;
    logic [IDX_W-1:0] ptr_q;

    // Load the index on an idle write; drop it after the one access it serves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            ptr_q   <= '0;
        end else if (armed_q && (ctl_wr || ctl_rd)) begin
            armed_q <= 1'b0;
            ptr_q   <= '0;
        end else if (!armed_q && ctl_wr) begin
            armed_q <= 1'b1;
            ptr_q   <= wr_idx;
        end
    end

    assign armed   = armed_q;
    assign cur_idx = ptr_q;
    assign reg_wr  = armed_q && ctl_wr;

    // R1
    ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (!armed_q && ptr_q == '0));

    // R1
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && ctl_wr) |=> (armed_q && ptr_q == $past(wr_idx)));

endmodule

// File: rtl/ser_wreg_file.sv
// Configuration register file and register 0 command decoder.
// Stores only the fields the channel uses. Decodes the channel reset code on
// register 9 and registers the command pulses decoded on register 0.
// Assumes reg_wr comes from the index sequencer and is never high on two
// consecutive cycles.
module ser_wreg_file
    import ser_chan_pkg::*;
#(
    parameter bit CHAN_B = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [IDX_W-1:0]   idx,
    input  byte_t              wdata,
    output logic               chan_rst,
    output logic               rx_en,
    output logic [LEN_W-1:0]   rx_len,
    output logic               tx_en,
    output logic [LEN_W-1:0]   tx_len,
    output logic               dtr,
    output logic               rts,
    output logic [1:0]         clk_mode,
    output logic [1:0]         stop_sel,
    output logic [1:0]         parity_sel,
    output byte_t              tc_lo,
    output byte_t              tc_hi,
    output logic               brg_run,
    output logic               brg_clocks,
    output cmd_t               cmd
);

    byte_t own_code;

    // Pick the reset code that belongs to this channel.
    generate
        if (CHAN_B) begin : g_chan_b
            assign own_code = RST_CODE_B;
        end else begin : g_chan_a
            assign own_code = RST_CODE_A;
        end
    endgenerate

    assign chan_rst = reg_wr && (idx == IX_RESET) && (wdata == own_code);

    logic cmd_sel;
    assign cmd_sel = reg_wr && (idx == IX_CMD);

    // Capture the configuration fields of an indexed write.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            rx_en      <= 1'b0;
            rx_len     <= '0;
            tx_en      <= 1'b0;
            tx_len     <= '0;
            dtr        <= 1'b0;
            rts        <= 1'b0;
            clk_mode   <= '0;
            stop_sel   <= '0;
            parity_sel <= '0;
            tc_lo      <= '0;
            tc_hi      <= '0;
            brg_run    <= 1'b0;
            brg_clocks <= 1'b0;
        end else if (reg_wr) begin
            case (idx)
                IX_RXCFG: begin
                    rx_en  <= wdata[0];
                    rx_len <= wdata[7:6];
                end
                IX_FRAME: begin
                    clk_mode   <= wdata[7:6];
                    stop_sel   <= wdata[3:2];
                    parity_sel <= wdata[1:0];
                end
                IX_TXCFG: begin
                    tx_en  <= wdata[3];
                    tx_len <= wdata[6:5];
                    dtr    <= wdata[7];
                    rts    <= wdata[1];
                end
                IX_CLKSRC: brg_clocks <= (wdata == CLKSRC_BRG);
                IX_TCLO:   tc_lo      <= wdata;
                IX_TCHI:   tc_hi      <= wdata;
                IX_BRGCTL: brg_run    <= (wdata == BRG_ON);
                default:   ;
            endcase
        end
    end

    // Turn a register 0 command byte into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '0;
        end else begin
            cmd.ext_rst   <= cmd_sel && (wdata == CMD_EXT);
            cmd.txint_clr <= cmd_sel && (wdata == CMD_TXCLR);
            cmd.ius_rst   <= cmd_sel && (wdata == CMD_IUS);
            cmd.err_rst   <= cmd_sel && (wdata == CMD_ERR);
        end
    end

    // R7
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd));

    // R7
    cmd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd) |=> !(|cmd));

    // R8
    chan_rst_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (!rx_en && !tx_en && !brg_run && tc_lo == '0 && tc_hi == '0));

endmodule

// File: rtl/ser_hold_path.sv
// Transmit and receive holding bytes with their flags and the receive mask.
// Assumes data_wr and data_rd are single-cycle host strobes. The shifter
// handshakes are level-sampled once per clock.
module ser_hold_path
    import ser_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_rst,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             data_wr,
    input  logic             data_rd,
    input  byte_t            wdata,
    input  logic             rx_strobe,
    input  byte_t            rx_byte,
    input  logic             tx_load,
    output byte_t            tx_hold,
    output logic             tx_empty,
    output logic             rx_avail,
    output byte_t            rx_masked
);

    byte_t rx_q;

    // Transmit holding byte: a host write beats a shifter load.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            tx_hold  <= '0;
            tx_empty <= 1'b1;
        end else if (data_wr) begin
            tx_hold  <= wdata;
            tx_empty <= 1'b0;
        end else if (tx_load && tx_en && !tx_empty) begin
            tx_empty <= 1'b1;
        end
    end

    // Receive holding byte: a new byte beats a host read of the old one.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            rx_q     <= '0;
            rx_avail <= 1'b0;
        end else if (rx_strobe && rx_en) begin
            rx_q     <= rx_byte;
            rx_avail <= 1'b1;
        end else if (data_rd) begin
            rx_avail <= 1'b0;
        end
    end

    assign rx_masked = rx_q & len_mask(rx_len);

    // R9
    tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !chan_rst) |=> (!tx_empty && tx_hold == $past(wdata)));

    // R9
    tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && tx_en && !tx_empty && !data_wr && !chan_rst) |=> tx_empty);

    // R10
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_en && !chan_rst) |=> rx_avail);

    // R8
    chan_rst_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (tx_empty && !rx_avail));

endmodule

// File: rtl/ser_chan_ctl.sv
// Host register front end for one asynchronous serial channel.
// Decodes the two host addresses and joins the index sequencer, the
// configuration register file and the holding-byte datapath. Read data is
// combinational from the current state and is zero when no read is active.
module ser_chan_ctl
    import ser_chan_pkg::*;
#(
    parameter bit CHAN_B = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                brk_in,
    input  logic                rx_strobe,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic                tx_load,
    output logic [BYTE_W-1:0]   tx_byte,
    output logic                tx_pending,
    output logic                rx_en,
    output logic [LEN_W-1:0]    rx_len,
    output logic                tx_en,
    output logic [LEN_W-1:0]    tx_len,
    output logic                dtr,
    output logic                rts,
    output logic [1:0]          clk_mode,
    output logic [1:0]          stop_sel,
    output logic [1:0]          parity_sel,
    output logic [2*BYTE_W-1:0] time_const,
    output logic                brg_run,
    output logic                brg_clocks,
    output logic                cmd_ext_rst,
    output logic                cmd_txint_clr,
    output logic                cmd_ius_rst,
    output logic                cmd_err_rst
);

    logic             ctl_wr, ctl_rd, data_wr, data_rd;
    logic             armed, reg_wr, chan_rst;
    logic [IDX_W-1:0] cur_idx;
    byte_t            tc_lo, tc_hi, rx_masked;
    logic             tx_empty, rx_avail;
    cmd_t             cmd;

    assign ctl_wr  = bus_sel &&  bus_wr && !bus_addr;
    assign ctl_rd  = bus_sel && !bus_wr && !bus_addr;
    assign data_wr = bus_sel &&  bus_wr &&  bus_addr;
    assign data_rd = bus_sel && !bus_wr &&  bus_addr;

    ser_ptr_seq i_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .ctl_rd  (ctl_rd),
        .wr_idx  (bus_wdata[IDX_W-1:0]),
        .armed   (armed),
        .cur_idx (cur_idx),
        .reg_wr  (reg_wr)
    );

    ser_wreg_file #(.CHAN_B(CHAN_B)) i_wreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .idx        (cur_idx),
        .wdata      (bus_wdata),
        .chan_rst   (chan_rst),
        .rx_en      (rx_en),
        .rx_len     (rx_len),
        .tx_en      (tx_en),
        .tx_len     (tx_len),
        .dtr        (dtr),
        .rts        (rts),
        .clk_mode   (clk_mode),
        .stop_sel   (stop_sel),
        .parity_sel (parity_sel),
        .tc_lo      (tc_lo),
        .tc_hi      (tc_hi),
        .brg_run    (brg_run),
        .brg_clocks (brg_clocks),
        .cmd        (cmd)
    );

    ser_hold_path i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_rst  (chan_rst),
        .rx_en     (rx_en),
        .tx_en     (tx_en),
        .rx_len    (rx_len),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .wdata     (bus_wdata),
        .rx_strobe (rx_strobe),
        .rx_byte   (rx_byte),
        .tx_load   (tx_load),
        .tx_hold   (tx_byte),
        .tx_empty  (tx_empty),
        .rx_avail  (rx_avail),
        .rx_masked (rx_masked)
    );

    assign tx_pending    = !tx_empty;
    assign time_const    = {tc_hi, tc_lo};
    assign cmd_ext_rst   = cmd.ext_rst;
    assign cmd_txint_clr = cmd.txint_clr;
    assign cmd_ius_rst   = cmd.ius_rst;
    assign cmd_err_rst   = cmd.err_rst;

    // Select host read data: masked receive byte, status, or readable register.
    always_comb begin
        bus_rdata = '0;
        if (data_rd) begin
            bus_rdata = rx_masked;
        end else if (ctl_rd) begin
            case (cur_idx)
                IX_CMD:  bus_rdata = {brk_in, 4'b0000, tx_empty, 1'b0, rx_avail};
                IX_TCLO: bus_rdata = tc_lo;
                IX_TCHI: bus_rdata = tc_hi;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R2
    idle_read_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !armed) |-> (bus_rdata[0] == rx_avail && bus_rdata[2] == !tx_pending));

endmodule

// File: tb/test_ser_chan_ctl.sv
// Bench: behavioural reference model advanced once per clock and compared
// with every output of the design just after each falling edge.
module test_ser_chan_ctl;

    localparam int CLK_P = 10;
    localparam logic [7:0] OWN_RST   = 8'h80;
    localparam logic [7:0] OTHER_RST = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr, bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        brk_in, rx_strobe, tx_load;
    logic [7:0]  rx_byte, tx_byte;
    logic        tx_pending, rx_en, tx_en, dtr, rts, brg_run, brg_clocks;
    logic [1:0]  rx_len, tx_len, clk_mode, stop_sel, parity_sel;
    logic [15:0] time_const;
    logic        cmd_ext_rst, cmd_txint_clr, cmd_ius_rst, cmd_err_rst;

    always #(CLK_P/2) clk = ~clk;

    ser_chan_ctl i_ser_chan_ctl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .brk_in(brk_in), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .tx_load(tx_load), .tx_byte(tx_byte), .tx_pending(tx_pending),
        .rx_en(rx_en), .rx_len(rx_len), .tx_en(tx_en), .tx_len(tx_len),
        .dtr(dtr), .rts(rts), .clk_mode(clk_mode), .stop_sel(stop_sel),
        .parity_sel(parity_sel), .time_const(time_const), .brg_run(brg_run),
        .brg_clocks(brg_clocks), .cmd_ext_rst(cmd_ext_rst),
        .cmd_txint_clr(cmd_txint_clr), .cmd_ius_rst(cmd_ius_rst),
        .cmd_err_rst(cmd_err_rst)
    );

    // Reference model state: whole bytes per register number, plain flags.
    logic [7:0] m_reg [16];
    bit         m_armed;
    int         m_ptr;
    logic [3:0] m_cmd;
    logic [7:0] m_txhold, m_rxhold;
    bit         m_txempty, m_rxavail;

    int    n_vec = 0;
    int    n_bad = 0;
    int    n_chk = 0;
    string phase = "R11";

    function automatic logic [7:0] mask_of(input logic [1:0] code);
        int bits;
        case (code)
            2'b00: bits = 5;
            2'b01: bits = 7;
            2'b10: bits = 6;
            default: bits = 8;
        endcase
        return 8'((1 << bits) - 1);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
        m_txhold = 8'h00; m_rxhold = 8'h00;
        m_txempty = 1'b1; m_rxavail = 1'b0;
    endtask

    task automatic model_reset();
        model_clear();
        m_armed = 1'b0; m_ptr = 0; m_cmd = 4'b0000;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) %s: actual %0h expected %0h",
                     tag, phase, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [7:0] exp_rd;
        string      rtag;
        exp_rd = 8'h00;
        rtag   = "R1";
        if (bus_sel && !bus_wr) begin
            if (bus_addr) begin
                exp_rd = m_rxhold & mask_of(m_reg[3][7:6]);
                rtag   = "R10";
            end else if (m_ptr == 0) begin
                exp_rd = {brk_in, 4'b0000, m_txempty, 1'b0, m_rxavail};
                rtag   = "R2";
            end else if (m_ptr == 12 || m_ptr == 13) begin
                exp_rd = m_reg[m_ptr];
                rtag   = "R5";
            end
        end
        chk(rtag,  "bus_rdata",     32'(bus_rdata), 32'(exp_rd));
        chk("R3",  "rx_en",         32'(rx_en),      32'(m_reg[3][0]));
        chk("R3",  "rx_len",        32'(rx_len),     32'(m_reg[3][7:6]));
        chk("R3",  "tx_en",         32'(tx_en),      32'(m_reg[5][3]));
        chk("R3",  "tx_len",        32'(tx_len),     32'(m_reg[5][6:5]));
        chk("R3",  "dtr",           32'(dtr),        32'(m_reg[5][7]));
        chk("R3",  "rts",           32'(rts),        32'(m_reg[5][1]));
        chk("R4",  "clk_mode",      32'(clk_mode),   32'(m_reg[4][7:6]));
        chk("R4",  "stop_sel",      32'(stop_sel),   32'(m_reg[4][3:2]));
        chk("R4",  "parity_sel",    32'(parity_sel), 32'(m_reg[4][1:0]));
        chk("R5",  "time_const",    32'(time_const), 32'({m_reg[13], m_reg[12]}));
        chk("R6",  "brg_run",       32'(brg_run),    32'(m_reg[14] == 8'h07));
        chk("R6",  "brg_clocks",    32'(brg_clocks), 32'(m_reg[11] == 8'h56));
        chk("R7",  "cmd_ext_rst",   32'(cmd_ext_rst),   32'(m_cmd[0]));
        chk("R7",  "cmd_txint_clr", 32'(cmd_txint_clr), 32'(m_cmd[1]));
        chk("R7",  "cmd_ius_rst",   32'(cmd_ius_rst),   32'(m_cmd[2]));
        chk("R7",  "cmd_err_rst",   32'(cmd_err_rst),   32'(m_cmd[3]));
        chk("R9",  "tx_byte",       32'(tx_byte),    32'(m_txhold));
        chk("R9",  "tx_pending",    32'(tx_pending), 32'(!m_txempty));
    endtask

    // Advance the model by one clock edge using the inputs now driven.
    task automatic model_step();
        bit cw, cr, dw, dr, own, txen_now, rxen_now;
        if (!rst_n) begin
            model_reset();
            return;
        end
        cw = bus_sel && bus_wr && !bus_addr;
        cr = bus_sel && !bus_wr && !bus_addr;
        dw = bus_sel && bus_wr && bus_addr;
        dr = bus_sel && !bus_wr && bus_addr;
        txen_now = m_reg[5][3];
        rxen_now = m_reg[3][0];
        own = cw && m_armed && m_ptr == 9 && bus_wdata == OWN_RST;
        m_cmd = 4'b0000;
        if (cw && m_armed && m_ptr == 0) begin
            if (bus_wdata == 8'h10) m_cmd[0] = 1'b1;
            if (bus_wdata == 8'h28) m_cmd[1] = 1'b1;
            if (bus_wdata == 8'h38) m_cmd[2] = 1'b1;
            if (bus_wdata == 8'hF0) m_cmd[3] = 1'b1;
        end
        if (own) begin
            model_clear();
        end else begin
            if (cw && m_armed) m_reg[m_ptr] = bus_wdata;
            if (dw) begin
                m_txhold = bus_wdata; m_txempty = 1'b0;
            end else if (tx_load && txen_now && !m_txempty) begin
                m_txempty = 1'b1;
            end
            if (rx_strobe && rxen_now) begin
                m_rxhold = rx_byte; m_rxavail = 1'b1;
            end else if (dr) begin
                m_rxavail = 1'b0;
            end
        end
        if (m_armed && (cw || cr)) begin
            m_armed = 1'b0; m_ptr = 0;
        end else if (!m_armed && cw) begin
            m_armed = 1'b1; m_ptr = int'(bus_wdata[3:0]);
        end
    endtask

    task automatic cyc();
        #1;
        n_vec++;
        compare();
        model_step();
        @(negedge clk);
    endtask

    task automatic quiet();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0;
        rx_strobe = 1'b0; tx_load = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic ctl_wr(input logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = v;
        cyc(); quiet();
    endtask

    task automatic ctl_rd();
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b0;
        cyc(); quiet();
    endtask

    task automatic dat_wr(input logic [7:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = v;
        cyc(); quiet();
    endtask

    task automatic dat_rd();
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
        cyc(); quiet();
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [7:0] v);
        ctl_wr({4'h0, idx}); ctl_wr(v);
    endtask

    task automatic rd_reg(input logic [3:0] idx);
        ctl_wr({4'h0, idx}); ctl_rd();
    endtask

    task automatic rx_feed(input logic [7:0] b);
        rx_strobe = 1'b1; rx_byte = b; cyc(); rx_strobe = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog (phase %s): actual hung expected finished", phase);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wdata = 8'h00; rx_byte = 8'h00; brk_in = 1'b0;
        quiet();
        model_reset();
        @(negedge clk); @(negedge clk);

        // R11: reset state held, then released
        phase = "R11";
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R2: idle control read returns status, break follows brk_in
        phase = "R2";
        ctl_rd();
        brk_in = 1'b1; ctl_rd(); brk_in = 1'b0;

        // R1: index load, indexed access, return to idle
        phase = "R1";
        wr_reg(4'd12, 8'h5A);
        rd_reg(4'd12);
        ctl_rd();
        wr_reg(4'd3, 8'h00);
        rd_reg(4'd3);
        ctl_wr(8'hF7); ctl_rd();
        ctl_rd();

        // R3: receiver and transmitter configuration fields
        phase = "R3";
        wr_reg(4'd3, 8'hC1);
        wr_reg(4'd5, 8'hEA);
        wr_reg(4'd5, 8'h28);

        // R4: framing fields in several patterns
        phase = "R4";
        wr_reg(4'd4, 8'hCE);
        wr_reg(4'd4, 8'h41);
        wr_reg(4'd4, 8'h86);

        // R5: time constant assembly and read-back
        phase = "R5";
        wr_reg(4'd12, 8'h1E);
        wr_reg(4'd13, 8'h00);
        wr_reg(4'd13, 8'hA5);
        rd_reg(4'd13);
        rd_reg(4'd12);

        // R6: generator enable and clock routing exact-value decode
        phase = "R6";
        wr_reg(4'd14, 8'h07);
        wr_reg(4'd11, 8'h56);
        wr_reg(4'd14, 8'h06);
        wr_reg(4'd11, 8'h57);
        wr_reg(4'd14, 8'h07);

        // R7: every command code and a near miss
        phase = "R7";
        wr_reg(4'd0, 8'h10); idle(1);
        wr_reg(4'd0, 8'h28); idle(1);
        wr_reg(4'd0, 8'h38); idle(1);
        wr_reg(4'd0, 8'hF0); idle(1);
        wr_reg(4'd0, 8'h20); idle(1);

        // R9: transmit holding byte and load handshake
        phase = "R9";
        wr_reg(4'd5, 8'h08);
        dat_wr(8'h3C);
        ctl_rd();
        tx_load = 1'b1; cyc(); tx_load = 1'b0;
        tx_load = 1'b1; cyc(); tx_load = 1'b0;
        dat_wr(8'h11);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h22;
        tx_load = 1'b1; cyc(); quiet();
        wr_reg(4'd5, 8'h00);
        tx_load = 1'b1; cyc(); tx_load = 1'b0;
        wr_reg(4'd5, 8'h08);
        tx_load = 1'b1; cyc(); tx_load = 1'b0;

        // R10: receive masking for every length, gating and collision
        phase = "R10";
        for (int len = 0; len < 4; len++) begin
            wr_reg(4'd3, {2'(len), 5'b00000, 1'b1});
            rx_feed(8'hFF);
            ctl_rd();
            dat_rd();
            ctl_rd();
        end
        wr_reg(4'd3, 8'h00);
        rx_feed(8'h5E);
        dat_rd();
        wr_reg(4'd3, 8'hC1);
        rx_feed(8'hA7);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
        rx_strobe = 1'b1; rx_byte = 8'h3B; cyc(); quiet();
        ctl_rd();
        dat_rd();
        ctl_rd();

        // R8: other channel code ignored, own code clears everything
        phase = "R8";
        wr_reg(4'd4, 8'hC5);
        wr_reg(4'd5, 8'hEA);
        wr_reg(4'd12, 8'h34);
        wr_reg(4'd13, 8'h12);
        dat_wr(8'h99);
        rx_feed(8'h66);
        wr_reg(4'd9, OTHER_RST);
        idle(1);
        wr_reg(4'd9, OWN_RST);
        idle(1);
        ctl_rd();
        dat_rd();

        // R11: reset in the middle of an indexed access
        phase = "R11";
        wr_reg(4'd3, 8'h41);
        ctl_wr(8'h0C);
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        ctl_rd();
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule